// File: doc/BRIEF.md
# Viterbi Metric Core (16-State Branch Metric and Add-Compare-Select)

This block computes the metrics of a Viterbi decoder for a rate-1/2 convolutional code with constraint length 5, so its trellis has 16 states. Each accepted symbol brings two 3-bit soft-decision samples, one for each coded bit. The block turns the pair into four branch metrics. It then runs add-compare-select in parallel for every state and keeps an 8-bit path metric per state.

For each accepted symbol the block emits a packed 16-bit word of survivor decisions, one bit per state, with a one-cycle valid flag. A traceback unit downstream consumes this word. Any single state's path metric can be read through a select input, for observation.

The metrics are renormalised every symbol, so the 8-bit registers never wrap.

Top module: `vit_metric_core`

## Requirements
- R1: While `rst` is high, and after it falls, state 0 holds metric 0 and every other state holds `INIT_METRIC` (default 128). `survivors` is all zeros and `survValid` is 0.
- R2: A received sample is compared with 3'b000 for a coded 0 and with 3'b111 for a coded 1. The branch metric is |softA - e0| + |softB - e1|, giving a range of 0 to 14. `softA` carries the coded bit from generator 10011 and `softB` the coded bit from generator 11101.
- R3: A state is the four most recent input bits, with the newest in bit 3. Input u moves state s to {u, s[3:1]}. The shift-register word is {u, s}, with u as the leftmost tap. The coded bits are c0 = u^s[1]^s[0] (generator 10011) and c1 = u^s[3]^s[2]^s[0] (generator 11101).
- R4: State n has two candidate predecessors, {n[2:0],0} and {n[2:0],1}. Its new metric is the smaller of predecessor metric plus branch metric. Bit n of `survivors` is the low bit of the chosen predecessor. On a tie the predecessor ending in 0 is chosen.
- R5: After every accepted symbol, the minimum of the raw new metrics is subtracted from all 16 of them, so the smallest stored metric is 0.
- R6: With the default `INIT_METRIC`, no 8-bit add-compare-select sum ever carries out, under any input sequence.
- R7: An accepted symbol (`symValid` high at a clock edge) updates `survivors` and the metrics at that edge. `survValid` is high for exactly the following cycle.
- R8: When `symValid` is low, the metrics and `survivors` keep their values and `survValid` is 0.
- R9: When `rst` and `symValid` are high in the same cycle, reset wins and the symbol is discarded.
- R10: `metricOut` shows the stored metric of the state chosen by `metricSel`, and follows `metricSel` without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | A new symbol is present on softA/softB |
| softA | input | 3 | Soft sample for the coded bit from generator 10011 |
| softB | input | 3 | Soft sample for the coded bit from generator 11101 |
| metricSel | input | 4 | State whose path metric is shown on metricOut |
| survivors | output | 16 | Survivor decision bits, bit n for state n |
| survValid | output | 1 | survivors was updated at the previous edge |
| metricOut | output | 8 | Stored path metric of the selected state |

## Verification
Reset and symbol acceptance can arrive in the same cycle. The bench raises `rst` while a symbol is presented, once at start-up and once partway through a stream. It then requires the exact initial metrics and a zero survivor word, which shows that no add-compare-select step slipped through. A second collision is renormalisation with a tie or a worst-case spread in the same update. Long streams of arbitrary sample pairs are compared, state by state, against a forward trellis model kept in the bench, and the model also flags any sum that would exceed 8 bits.

// File: rtl/vit_pkg.sv
`timescale 1ns/1ps
package vit_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic initPm;  // load the start-of-trellis metrics
    logic acsEn;   // run one add-compare-select step
  } vitStrobeT;
endpackage

// File: rtl/vit_bmu.sv
`timescale 1ns/1ps
module vit_bmu #(
  parameter int SOFT_W = 3,
  parameter int BMW    = SOFT_W + 1
) (
  input  logic [SOFT_W-1:0]      softA,
  input  logic [SOFT_W-1:0]      softB,
  output logic [3:0][BMW-1:0]    bm      // index {c1,c0}
);
  localparam logic [SOFT_W-1:0] TOP = '1;

  for (genvar i = 0; i < 4; i++) begin : g_bm
    localparam bit C0 = (i % 2) == 1;
    localparam bit C1 = (i / 2) == 1;
    logic [SOFT_W-1:0] distA, distB;
    assign distA = C0 ? (TOP - softA) : softA;
    assign distB = C1 ? (TOP - softB) : softB;
    assign bm[i] = BMW'(distA) + BMW'(distB);
  end
endmodule

// File: rtl/vit_ctrl.sv
`timescale 1ns/1ps
module vit_ctrl
  import vit_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      symValid,
  output vitStrobeT strobes,
  output logic      survValid
);
  always_comb begin
    strobes.initPm = rst;
    strobes.acsEn  = symValid & ~rst;  // reset has priority
  end

  always_ff @(posedge clk) begin
    if (rst) survValid <= 1'b0;
    else     survValid <= symValid;
  end

  // R7: flag is a one-cycle echo of an accepted symbol
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    symValid |=> survValid);
  assert_valid_low_R7: assert property (@(posedge clk) disable iff (rst)
    !symValid |=> !survValid);
endmodule

// File: rtl/vit_acs_path.sv
`timescale 1ns/1ps
module vit_acs_path
  import vit_pkg::*;
#(
  parameter int             K           = 5,
  parameter int             SOFT_W      = 3,
  parameter int             MW          = 8,
  parameter logic [K-1:0]   G0          = 5'b10011,
  parameter logic [K-1:0]   G1          = 5'b11101,
  parameter int             INIT_METRIC = 128
) (
  input  logic                       clk,
  input  vitStrobeT                  strobes,
  input  logic [SOFT_W-1:0]          softA,
  input  logic [SOFT_W-1:0]          softB,
  input  logic [K-2:0]               metricSel,
  output logic [(1<<(K-1))-1:0]      survivors,
  output logic [MW-1:0]              metricOut
);
  localparam int SW  = K - 1;
  localparam int NS  = 1 << SW;
  localparam int BMW = SOFT_W + 1;

  logic [3:0][BMW-1:0] bm;
  logic [NS-1:0][MW-1:0] pmQ, pmNew, pmD;
  logic [NS-1:0] dec, carry0, carry1;
  logic [MW-1:0] minV;
  logic pmHasZero;

  vit_bmu #(.SOFT_W(SOFT_W), .BMW(BMW)) u_bmu (
    .softA(softA), .softB(softB), .bm(bm)
  );

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam int U  = n / (NS / 2);
    localparam int P0 = (n * 2) % NS;
    localparam int P1 = P0 + 1;
    localparam logic [K-1:0] REG0 = K'(U * NS + P0);
    localparam logic [K-1:0] REG1 = K'(U * NS + P1);
    localparam int IDX0 = 2 * int'(^(G1 & REG0)) + int'(^(G0 & REG0));
    localparam int IDX1 = 2 * int'(^(G1 & REG1)) + int'(^(G0 & REG1));
    logic [MW:0] sum0, sum1, diff;
    logic pick1;
    assign sum0  = {1'b0, pmQ[P0]} + (MW+1)'(bm[IDX0]);
    assign sum1  = {1'b0, pmQ[P1]} + (MW+1)'(bm[IDX1]);
    assign diff  = {1'b0, sum0[MW-1:0]} - {1'b0, sum1[MW-1:0]};
    assign pick1 = ~diff[MW] & (|diff[MW-1:0]);  // strictly smaller via odd branch
    assign pmNew[n]  = pick1 ? sum1[MW-1:0] : sum0[MW-1:0];
    assign dec[n]    = pick1;
    assign carry0[n] = sum0[MW];
    assign carry1[n] = sum1[MW];
  end

  always_comb begin
    minV = pmNew[0];
    for (int i = 1; i < NS; i++)
      if (pmNew[i] < minV) minV = pmNew[i];
    for (int i = 0; i < NS; i++)
      pmD[i] = pmNew[i] - minV;
  end

  always_ff @(posedge clk) begin
    if (strobes.initPm) begin
      for (int i = 0; i < NS; i++)
        pmQ[i] <= (i == 0) ? '0 : MW'(INIT_METRIC);
      survivors <= '0;
    end else if (strobes.acsEn) begin
      pmQ       <= pmD;
      survivors <= dec;
    end
  end

  assign metricOut = pmQ[metricSel];

  always_comb begin
    pmHasZero = 1'b0;
    for (int i = 0; i < NS; i++)
      if (pmQ[i] == '0) pmHasZero = 1'b1;
  end

  // R6: no add-compare-select sum leaves 8 bits
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (strobes.initPm)
    strobes.acsEn |-> (carry0 == '0 && carry1 == '0));
  // R5: stored metrics are renormalised to a zero minimum
  assert_min_zero_R5: assert property (@(posedge clk) disable iff (strobes.initPm)
    strobes.acsEn |=> pmHasZero);
  // R8: idle cycles leave metrics and decisions untouched
  assert_hold_R8: assert property (@(posedge clk) disable iff (strobes.initPm)
    !strobes.acsEn |=> ($stable(pmQ) && $stable(survivors)));
  // R1: right after reset the start metrics are in place
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (strobes.initPm)
    $fell(strobes.initPm) |-> (pmQ[0] == '0 && pmQ[NS-1] == MW'(INIT_METRIC) && survivors == '0));
endmodule

// File: rtl/vit_metric_core.sv
`timescale 1ns/1ps
module vit_metric_core
  import vit_pkg::*;
#(
  parameter int             K           = 5,
  parameter int             SOFT_W      = 3,
  parameter int             MW          = 8,
  parameter logic [K-1:0]   G0          = 5'b10011,
  parameter logic [K-1:0]   G1          = 5'b11101,
  parameter int             INIT_METRIC = 128
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   symValid,
  input  logic [SOFT_W-1:0]      softA,
  input  logic [SOFT_W-1:0]      softB,
  input  logic [K-2:0]           metricSel,
  output logic [(1<<(K-1))-1:0]  survivors,
  output logic                   survValid,
  output logic [MW-1:0]          metricOut
);
  vitStrobeT strobes;

  vit_ctrl u_ctrl (
    .clk(clk), .rst(rst), .symValid(symValid),
    .strobes(strobes), .survValid(survValid)
  );

  vit_acs_path #(
    .K(K), .SOFT_W(SOFT_W), .MW(MW), .G0(G0), .G1(G1), .INIT_METRIC(INIT_METRIC)
  ) u_path (
    .clk(clk), .strobes(strobes), .softA(softA), .softB(softB),
    .metricSel(metricSel), .survivors(survivors), .metricOut(metricOut)
  );
endmodule

// File: tb/sim_vit_metric_core.sv
`timescale 1ns/1ps
module sim_vit_metric_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic symValid = 1'b0;
  logic [2:0] softA = '0, softB = '0;
  logic [3:0] metricSel = '0;
  logic [15:0] survivors;
  logic survValid;
  logic [7:0] metricOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int pmM[16];
  logic [15:0] survM;

  // vectors {softA, softB}
  localparam int NV = 24;
  localparam logic [5:0] VEC [NV] = '{
    6'o77, 6'o07, 6'o00, 6'o77, 6'o07, 6'o70, 6'o44, 6'o33,
    6'o16, 6'o61, 6'o25, 6'o52, 6'o00, 6'o00, 6'o77, 6'o34,
    6'o43, 6'o70, 6'o07, 6'o11, 6'o66, 6'o17, 6'o71, 6'o00 };

  always #4 clk = ~clk;  // 125 MHz

  vit_metric_core u0 (
    .clk(clk), .rst(rst), .symValid(symValid), .softA(softA), .softB(softB),
    .metricSel(metricSel), .survivors(survivors), .survValid(survValid),
    .metricOut(metricOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int par(input int v);
    int p = 0;
    for (int i = 0; i < 5; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) pmM[i] = (i == 0) ? 0 : 128;
    survM = '0;
  endtask

  // forward trellis model per R2..R6
  task automatic modelStep(input int a, input int b);
    int nxt[16];
    int mn;
    for (int i = 0; i < 16; i++) nxt[i] = -1;
    for (int p = 0; p < 16; p++) begin
      for (int u = 0; u < 2; u++) begin
        int n = u * 8 + p / 2;
        int r = u * 16 + p;
        int c0 = par(r & 5'b10011);
        int c1 = par(r & 5'b11101);
        int bmv = (c0 != 0 ? 7 - a : a) + (c1 != 0 ? 7 - b : b);
        int cand = pmM[p] + bmv;
        if (cand > 255) chk("R6 sum fits 8 bits", cand, 255);
        if (nxt[n] < 0 || cand < nxt[n]) begin
          nxt[n] = cand;
          survM[n] = p[0];
        end
      end
    end
    mn = nxt[0];
    for (int i = 1; i < 16; i++) if (nxt[i] < mn) mn = nxt[i];
    for (int i = 0; i < 16; i++) pmM[i] = nxt[i] - mn;
  endtask

  task automatic sweepMetrics(input string req);
    int mn = 999;
    for (int s = 0; s < 16; s++) begin
      metricSel = 4'(s);
      #0.1;
      chk(req, int'(metricOut), pmM[s]);  // R10 combinational select
      if (int'(metricOut) < mn) mn = int'(metricOut);
    end
    chk("R5 minimum metric is zero", mn, 0);
  endtask

  task automatic applySym(input logic [2:0] a, input logic [2:0] b, input string req);
    @(negedge clk);
    softA = a; softB = b; symValid = 1'b1;
    @(negedge clk);
    symValid = 1'b0;
    modelStep(int'(a), int'(b));
    chk("R7 survValid after symbol", int'(survValid), 1);
    chk(req, int'(survivors), int'(survM));
    sweepMetrics(req);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; symValid = 1'b1; softA = 3'd7; softB = 3'd7;  // R9 collision
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; symValid = 1'b0;
    modelReset();
    chk("R1 survValid after reset", int'(survValid), 0);
    chk("R9 survivors after reset", int'(survivors), 0);
    for (int s = 0; s < 16; s++) begin
      metricSel = 4'(s);
      #0.1;
      chk("R1 R9 reset metric", int'(metricOut), (s == 0) ? 0 : 128);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [15:0] held;
    modelReset();
    doReset();

    // R2 R3: clean codeword for input 1 from state 0 -> state 8 metric 0, state 0 metric 14
    applySym(3'd7, 3'd7, "R2 R3 R4 first symbol");
    metricSel = 4'd8; #0.1; chk("R3 state 8 metric", int'(metricOut), 0);
    metricSel = 4'd0; #0.1; chk("R2 state 0 metric", int'(metricOut), 14);

    // R4 tie: state 1 predecessors 2 and 3 both at 128 with branch metric 7 each
    doReset();
    applySym(3'd4, 3'd4, "R4 tie symbol");
    chk("R4 tie picks even predecessor", int'(survivors[1]), 0);

    // table walk
    doReset();
    for (int i = 0; i < NV; i++)
      applySym(VEC[i][5:3], VEC[i][2:0], "R4 R5 table vector");

    // R8 idle: nothing moves, flag low
    held = survivors;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8 survValid idle", int'(survValid), 0);
      chk("R8 survivors held", int'(survivors), int'(held));
    end
    sweepMetrics("R8 metrics held");

    // R6 stress with arbitrary samples
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      applySym(lf[2:0], lf[5:3], "R6 stress");
      for (int j = 0; j < 6; j++)
        lf = lf[0] ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
    end

    // R9 mid-stream collision
    doReset();
    applySym(3'd0, 3'd7, "R9 after mid-stream reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule